// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA Request Unit

This unit sits between the serial shift engine of an SPI controller and the bus-side register file. It holds a transmit queue and a receive queue, reports their fill levels and a five-bit status word, and turns queue conditions into interrupts and DMA requests. The transmit queue is filled by single-cycle bus writes and drained by the shift engine over a valid/ready stream. The receive queue is filled by the shift engine over a valid/ready stream and drained by single-cycle bus reads.

Two threshold levels drive the level-type interrupts: a transmit-low interrupt and a receive-high interrupt. Three sticky error flags record a write to a full transmit queue, a read from an empty receive queue and a beat lost at a full receive queue. A five-bit mask selects which raw sources reach the single interrupt line. A four-bit clear strobe clears the error flags one at a time or all at once. Two DMA request lines, each gated by its own enable bit and compared against its own watermark, ask for refills and drains.

Back-pressure rules: on the transmit output stream a word moves on a cycle where both `tx_out_valid` and `tx_out_ready` are high, and the shift engine may hold ready low as long as it likes. The receive input stream drives `rx_in_ready` low while the receive queue is full or the unit is disabled. The shift engine cannot stall a serial receive, so a beat offered while ready is low and the unit is enabled is lost and raises the receive overflow flag.

Top module: `spi_fifo_hub`

## Requirements
- R1: After reset both fill levels are 0, the status word is 0x0C, the raw interrupt word is 0x01, and `irq`, `tx_dma_req` and `rx_dma_req` are low while mask and DMA enables are 0.
- R2: Words written with `tx_push` while enabled appear on `tx_out_data` in the order written, one per accepted handshake, and `tx_level` counts the words held (at most DEPTH).
- R3: A `tx_push` while enabled and the transmit queue holds DEPTH words is dropped, the level stays DEPTH, and raw interrupt bit 1 (transmit overflow) is set one cycle later and stays set until cleared.
- R4: Received words leave on `rx_pop_data` in arrival order, with the data valid in the cycle `rx_pop` is high. A pop from an empty receive queue returns 0, leaves the level at 0, and sets sticky raw bit 2 (receive underflow).
- R5: With the receive queue full, `rx_in_ready` is low; a beat offered anyway while enabled is lost, the level stays DEPTH, the stored data is untouched, and sticky raw bit 3 (receive overflow) is set.
- R6: A `clr_wr` cycle clears error flags by `clr_bits`: bit 0 clears all three, bit 1 receive underflow, bit 2 receive overflow, bit 3 transmit overflow. A new error event in the same cycle as its clear leaves the flag set.
- R7: Raw bit 0 (transmit low) is high exactly while `tx_level` is less than or equal to `tx_thr`.
- R8: Raw bit 4 (receive high) is high exactly while `rx_level` is strictly greater than `rx_thr`.
- R9: `masked_int` equals `raw_int` ANDed with `int_mask`, and `irq` is the OR of the five masked bits.
- R10: A threshold write takes effect only when `enable` is low and the written value is below DEPTH; otherwise the register keeps its value, so reading back reveals the depth.
- R11: Status bits are: bit 0 busy (`engine_busy`, or enabled with transmit data pending), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R12: `tx_dma_req` is `dma_ctrl[1]` AND (`tx_level` <= `tx_dma_wm`); `rx_dma_req` is `dma_ctrl[0]` AND (`rx_level` > `rx_dma_wm`).
- R13: While `enable` is low both queues are emptied on the next edge, pushes from either side are ignored without raising an error flag, and `tx_out_valid` and `rx_in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low flushes both queues and unlocks thresholds |
| engine_busy | input | 1 | Shift engine reports a frame in progress |
| tx_push | input | 1 | Bus write strobe into the transmit queue |
| tx_push_data | input | 16 | Word written into the transmit queue |
| tx_out_valid | output | 1 | Transmit queue has a word for the shift engine |
| tx_out_ready | input | 1 | Shift engine takes the head word |
| tx_out_data | output | 16 | Head word of the transmit queue |
| rx_in_valid | input | 1 | Shift engine offers a received word |
| rx_in_ready | output | 1 | Receive queue can accept a word |
| rx_in_data | input | 16 | Received word from the shift engine |
| rx_pop | input | 1 | Bus read strobe from the receive queue |
| rx_pop_data | output | 16 | Head word of the receive queue, 0 when empty |
| tx_thr_wr | input | 1 | Write strobe for the transmit threshold |
| rx_thr_wr | input | 1 | Write strobe for the receive threshold |
| thr_wdata | input | 6 | Value for a threshold write |
| tx_thr | output | 6 | Current transmit threshold |
| rx_thr | output | 6 | Current receive threshold |
| int_mask | input | 5 | Interrupt mask, one bit per raw source |
| clr_wr | input | 1 | Strobe for the error-flag clear |
| clr_bits | input | 4 | Clear selection used with `clr_wr` |
| dma_ctrl | input | 2 | DMA enables: bit 0 receive, bit 1 transmit |
| tx_dma_wm | input | 6 | Transmit DMA watermark |
| rx_dma_wm | input | 6 | Receive DMA watermark |
| tx_level | output | 6 | Words in the transmit queue |
| rx_level | output | 6 | Words in the receive queue |
| status | output | 5 | Status word |
| raw_int | output | 5 | Raw interrupt sources |
| masked_int | output | 5 | Raw sources after the mask |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that `clr_bits` is only meaningful with `clr_wr` high and that `tx_out_ready` and `rx_in_valid` carry known values after reset. They make no assumption about the shift engine honouring `rx_in_ready`, since the receive overflow check depends on beats that ignore it. The stimulus changes every input on the falling clock edge and raises each strobe for exactly one cycle. It drives overflow and underflow only on purpose, in the scenarios that test them. Threshold writes happen in disabled and enabled phases, so the lock check sees both cases.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

  // status word bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_TXFUL = 1;
  localparam int ST_TXEMP = 2;
  localparam int ST_RXEMP = 3;
  localparam int ST_RXFUL = 4;

  // interrupt source bit positions
  localparam int IRQ_TXLOW = 0;
  localparam int IRQ_TXOVF = 1;
  localparam int IRQ_RXUNF = 2;
  localparam int IRQ_RXOVF = 3;
  localparam int IRQ_RXHI  = 4;

  // clear strobe bit positions
  localparam int CLR_ALL   = 0;
  localparam int CLR_RXUNF = 1;
  localparam int CLR_RXOVF = 2;
  localparam int CLR_TXOVF = 3;

  // DMA enable bit positions
  localparam int DMA_RX_EN = 0;
  localparam int DMA_TX_EN = 1;

  typedef logic [4:0] irq_vec_t;
  typedef logic [4:0] stat_vec_t;
  typedef logic [3:0] clr_vec_t;

endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == FULL_L);
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rp];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_P) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == LAST_P) ? '0 : rp + PW'(1);
      count <= count + LW'(do_push) - LW'(do_pop);
    end
  end

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_L);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (level == '0));

endmodule

// File: rtl/sfh_thr_reg.sv
module sfh_thr_reg #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] thr
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic accept;
  assign accept = wr & ~enable & (wdata < DEPTH_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr <= '0;
    else if (accept) thr <= wdata;
  end

  p_thr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(thr));

  p_thr_keep_big_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wdata >= DEPTH_L)) |=> $stable(thr));

endmodule

// File: rtl/sfh_irq_ctl.sv
module sfh_irq_ctl
  import sfh_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_thr,
  input  logic          ev_txovf,
  input  logic          ev_rxunf,
  input  logic          ev_rxovf,
  input  logic          clr_wr,
  input  clr_vec_t      clr_bits,
  input  irq_vec_t      int_mask,
  output irq_vec_t      raw_int,
  output irq_vec_t      masked_int,
  output logic          irq
);

  logic flg_txovf, flg_rxunf, flg_rxovf;
  logic clr_txovf, clr_rxunf, clr_rxovf;

  assign clr_txovf = clr_wr & (clr_bits[CLR_ALL] | clr_bits[CLR_TXOVF]);
  assign clr_rxunf = clr_wr & (clr_bits[CLR_ALL] | clr_bits[CLR_RXUNF]);
  assign clr_rxovf = clr_wr & (clr_bits[CLR_ALL] | clr_bits[CLR_RXOVF]);

  // an event in the clearing cycle wins so that no error is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_txovf <= 1'b0;
      flg_rxunf <= 1'b0;
      flg_rxovf <= 1'b0;
    end else begin
      if (ev_txovf)       flg_txovf <= 1'b1;
      else if (clr_txovf) flg_txovf <= 1'b0;
      if (ev_rxunf)       flg_rxunf <= 1'b1;
      else if (clr_rxunf) flg_rxunf <= 1'b0;
      if (ev_rxovf)       flg_rxovf <= 1'b1;
      else if (clr_rxovf) flg_rxovf <= 1'b0;
    end
  end

  always_comb begin
    raw_int            = '0;
    raw_int[IRQ_TXLOW] = (tx_level <= tx_thr);
    raw_int[IRQ_TXOVF] = flg_txovf;
    raw_int[IRQ_RXUNF] = flg_rxunf;
    raw_int[IRQ_RXOVF] = flg_rxovf;
    raw_int[IRQ_RXHI]  = (rx_level > rx_thr);
  end

  assign masked_int = raw_int & int_mask;
  assign irq        = |masked_int;

  p_txovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_int[IRQ_TXOVF] && !clr_txovf) |=> raw_int[IRQ_TXOVF]);

  p_rxunf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_int[IRQ_RXUNF] && !clr_rxunf) |=> raw_int[IRQ_RXUNF]);

  p_rxovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_int[IRQ_RXOVF] && !clr_rxovf) |=> raw_int[IRQ_RXOVF]);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[CLR_ALL] && !ev_txovf && !ev_rxunf && !ev_rxovf)
      |=> (raw_int[IRQ_RXOVF:IRQ_TXOVF] == 3'b000));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxunf |=> raw_int[IRQ_RXUNF]);

  p_rxhi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !raw_int[IRQ_RXHI]);

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == '0) |-> !irq);

endmodule

// File: rtl/sfh_dma_req.sv
module sfh_dma_req #(
  parameter int LW    = 6,
  parameter bit ABOVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] wm,
  output logic          req
);

  logic hit;

  generate
    if (ABOVE) begin : g_drain
      assign hit = (level > wm);
    end else begin : g_refill
      assign hit = (level <= wm);
    end
  endgenerate

  assign req = en & hit;

  p_dma_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req);

endmodule

// File: rtl/spi_fifo_hub.sv
module spi_fifo_hub
  import sfh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          engine_busy,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  input  logic          tx_thr_wr,
  input  logic          rx_thr_wr,
  input  logic [LW-1:0] thr_wdata,
  output logic [LW-1:0] tx_thr,
  output logic [LW-1:0] rx_thr,
  input  logic [4:0]    int_mask,
  input  logic          clr_wr,
  input  logic [3:0]    clr_bits,
  input  logic [1:0]    dma_ctrl,
  input  logic [LW-1:0] tx_dma_wm,
  input  logic [LW-1:0] rx_dma_wm,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [4:0]    status,
  output logic [4:0]    raw_int,
  output logic [4:0]    masked_int,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  logic          flush;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_pop;
  logic [DW-1:0] rx_head;
  logic          ev_txovf, ev_rxunf, ev_rxovf;
  stat_vec_t     st;

  assign flush = ~enable;

  // transmit queue: bus writes in, shift engine drains
  assign tx_pop       = tx_out_valid & tx_out_ready;
  assign tx_out_valid = enable & ~tx_empty;

  sfh_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (tx_push & enable),
    .push_data (tx_push_data),
    .pop       (tx_pop),
    .head      (tx_out_data),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  // receive queue: shift engine fills, bus reads drain
  assign rx_in_ready = enable & ~rx_full;

  sfh_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (rx_in_valid & enable),
    .push_data (rx_in_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign rx_pop_data = rx_empty ? '0 : rx_head;

  // error events
  assign ev_txovf = enable & tx_push & tx_full;
  assign ev_rxovf = enable & rx_in_valid & rx_full;
  assign ev_rxunf = rx_pop & rx_empty;

  // thresholds
  sfh_thr_reg #(.DEPTH(DEPTH)) u_txthr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .wr     (tx_thr_wr),
    .wdata  (thr_wdata),
    .thr    (tx_thr)
  );

  sfh_thr_reg #(.DEPTH(DEPTH)) u_rxthr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .wr     (rx_thr_wr),
    .wdata  (thr_wdata),
    .thr    (rx_thr)
  );

  sfh_irq_ctl #(.LW(LW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_thr     (tx_thr),
    .rx_thr     (rx_thr),
    .ev_txovf   (ev_txovf),
    .ev_rxunf   (ev_rxunf),
    .ev_rxovf   (ev_rxovf),
    .clr_wr     (clr_wr),
    .clr_bits   (clr_bits),
    .int_mask   (int_mask),
    .raw_int    (raw_int),
    .masked_int (masked_int),
    .irq        (irq)
  );

  sfh_dma_req #(.LW(LW), .ABOVE(1'b0)) u_txdma (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (dma_ctrl[DMA_TX_EN]),
    .level (tx_level),
    .wm    (tx_dma_wm),
    .req   (tx_dma_req)
  );

  sfh_dma_req #(.LW(LW), .ABOVE(1'b1)) u_rxdma (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (dma_ctrl[DMA_RX_EN]),
    .level (rx_level),
    .wm    (rx_dma_wm),
    .req   (rx_dma_req)
  );

  // status word
  always_comb begin
    st           = '0;
    st[ST_BUSY]  = engine_busy | (enable & ~tx_empty);
    st[ST_TXFUL] = tx_full;
    st[ST_TXEMP] = tx_empty;
    st[ST_RXEMP] = rx_empty;
    st[ST_RXFUL] = rx_full;
  end
  assign status = st;

  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == '0 && rx_level == '0));

  p_no_err_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !raw_int[IRQ_TXOVF]) |=> !raw_int[IRQ_TXOVF]);

  p_tx_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_TXFUL] && status[ST_TXEMP]));

endmodule

// File: tb/sim_spi_fifo_hub.sv
module sim_spi_fifo_hub;
  localparam int DW    = 16;
  localparam int DEPTH = 32;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0, engine_busy = 1'b0;
  logic          tx_push = 1'b0;
  logic [DW-1:0] tx_push_data = '0;
  logic          tx_out_valid, tx_out_ready = 1'b0;
  logic [DW-1:0] tx_out_data;
  logic          rx_in_valid = 1'b0, rx_in_ready;
  logic [DW-1:0] rx_in_data = '0;
  logic          rx_pop = 1'b0;
  logic [DW-1:0] rx_pop_data;
  logic          tx_thr_wr = 1'b0, rx_thr_wr = 1'b0;
  logic [LW-1:0] thr_wdata = '0, tx_thr, rx_thr;
  logic [4:0]    int_mask = '0;
  logic          clr_wr = 1'b0;
  logic [3:0]    clr_bits = '0;
  logic [1:0]    dma_ctrl = '0;
  logic [LW-1:0] tx_dma_wm = '0, rx_dma_wm = '0;
  logic [LW-1:0] tx_level, rx_level;
  logic [4:0]    status, raw_int, masked_int;
  logic          irq, tx_dma_req, rx_dma_req;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  spi_fifo_hub #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_tx(input logic [DW-1:0] d);
    tx_push = 1'b1; tx_push_data = d; cyc(); tx_push = 1'b0;
  endtask

  task automatic feed_rx(input logic [DW-1:0] d);
    rx_in_valid = 1'b1; rx_in_data = d; cyc(); rx_in_valid = 1'b0;
  endtask

  task automatic pop_rx();
    rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
  endtask

  task automatic take_tx();
    tx_out_ready = 1'b1; cyc(); tx_out_ready = 1'b0;
  endtask

  task automatic wr_thr(input bit rx, input int v);
    tx_thr_wr = !rx; rx_thr_wr = rx; thr_wdata = LW'(v);
    cyc(); tx_thr_wr = 1'b0; rx_thr_wr = 1'b0;
  endtask

  task automatic clear(input logic [3:0] b);
    clr_wr = 1'b1; clr_bits = b; cyc(); clr_wr = 1'b0; clr_bits = '0;
  endtask

  task automatic t_reset();
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 status", int'(status), 'h0C);
    chk("R1 raw_int", int'(raw_int), 'h01);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'({tx_dma_req, rx_dma_req}), 0);
  endtask

  task automatic t_thresholds();
    wr_thr(0, 5);  chk("R10 tx_thr write", int'(tx_thr), 5);
    wr_thr(0, DEPTH); chk("R10 depth write dropped", int'(tx_thr), 5);
    wr_thr(0, DEPTH - 1); chk("R10 top value kept", int'(tx_thr), DEPTH - 1);
    wr_thr(1, 3);  chk("R10 rx_thr write", int'(rx_thr), 3);
    enable = 1'b1; cyc();
    wr_thr(0, 2);  chk("R10 locked while enabled", int'(tx_thr), DEPTH - 1);
    enable = 1'b0; cyc();
    wr_thr(0, 4);  chk("R10 unlocked again", int'(tx_thr), 4);
  endtask

  task automatic t_tx_path();
    enable = 1'b1; cyc();
    for (int i = 0; i < 6; i++) push_tx(DW'('h100 + i));
    chk("R2 tx_level", int'(tx_level), 6);
    chk("R11 status busy+rxempty", int'(status), 'h09);
    chk("R7 tx low off", int'(raw_int[0]), 0);
    dma_ctrl = 2'b10; tx_dma_wm = 6; #1;
    chk("R12 tx dma at wm", int'(tx_dma_req), 1);
    tx_dma_wm = 5; #1;
    chk("R12 tx dma above wm", int'(tx_dma_req), 0);
    for (int i = 0; i < 2; i++) begin
      chk("R2 tx order", int'(tx_out_data), 'h100 + i);
      take_tx();
    end
    chk("R7 tx low at thr", int'(raw_int[0]), 1);
    int_mask = 5'b00001; #1;
    chk("R9 irq unmasked", int'({irq, masked_int}), 'h21);
    int_mask = 5'b00000; #1;
    chk("R9 irq masked", int'(irq), 0);
    for (int i = 2; i < 6; i++) begin
      chk("R2 tx order", int'(tx_out_data), 'h100 + i);
      take_tx();
    end
    chk("R2 tx drained", int'({tx_out_valid, tx_level}), 0);
    chk("R11 status idle", int'(status), 'h0C);
    dma_ctrl = 2'b00;
  endtask

  task automatic t_tx_overflow();
    for (int i = 0; i < DEPTH; i++) push_tx(DW'('h200 + i));
    chk("R3 full level", int'(tx_level), DEPTH);
    chk("R11 status tx full", int'(status), 'h0B);
    push_tx(16'hDEAD);
    chk("R3 level held", int'(tx_level), DEPTH);
    chk("R3 overflow flag", int'(raw_int[1]), 1);
    chk("R3 head intact", int'(tx_out_data), 'h200);
    take_tx();
    chk("R3 flag sticky", int'(raw_int[1]), 1);
    clear(4'b1000);
    chk("R6 clear tx overflow", int'(raw_int[1]), 0);
    enable = 1'b0; cyc();
    chk("R13 tx flushed", int'({tx_out_valid, tx_level}), 0);
    push_tx(16'h0BAD);
    chk("R13 push ignored", int'(tx_level), 0);
    chk("R13 no overflow flag", int'(raw_int[1]), 0);
  endtask

  task automatic t_rx_path();
    enable = 1'b1; cyc();
    for (int i = 0; i < 3; i++) feed_rx(DW'('h300 + i));
    chk("R8 rx level", int'(rx_level), 3);
    chk("R8 equal not above", int'(raw_int[4]), 0);
    feed_rx(DW'('h303));
    chk("R8 above threshold", int'(raw_int[4]), 1);
    dma_ctrl = 2'b01; rx_dma_wm = 3; #1;
    chk("R12 rx dma above wm", int'(rx_dma_req), 1);
    rx_dma_wm = 4; #1;
    chk("R12 rx dma at wm", int'(rx_dma_req), 0);
    dma_ctrl = 2'b00; rx_dma_wm = 3; #1;
    chk("R12 rx dma disabled", int'(rx_dma_req), 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 rx order", int'(rx_pop_data), 'h300 + i);
      pop_rx();
    end
    chk("R4 rx empty data", int'({rx_level, rx_pop_data}), 0);
    pop_rx();
    chk("R4 underflow flag", int'(raw_int[2]), 1);
    chk("R4 level stays 0", int'(rx_level), 0);
  endtask

  task automatic t_rx_overflow();
    for (int i = 0; i < DEPTH; i++) feed_rx(DW'('h400 + i));
    chk("R5 rx full level", int'(rx_level), DEPTH);
    chk("R5 ready low", int'(rx_in_ready), 0);
    chk("R11 status rx full", int'(status), 'h14);
    feed_rx(16'hBEEF);
    chk("R5 level held", int'(rx_level), DEPTH);
    chk("R5 overflow flag", int'(raw_int[3]), 1);
    chk("R5 head intact", int'(rx_pop_data), 'h400);
  endtask

  task automatic t_clear();
    int_mask = 5'b00100; #1;
    chk("R9 error irq", int'({irq, masked_int}), 'h24);
    int_mask = '0;
    clear(4'b0100);
    chk("R6 clear rx overflow only", int'(raw_int[3:2]), 'b01);
    clear(4'b0001);
    chk("R6 clear all", int'(raw_int[3:1]), 0);
    enable = 1'b0; cyc();
    chk("R13 rx flushed", int'({rx_in_ready, rx_level}), 0);
    feed_rx(16'h1234);
    chk("R13 rx push ignored", int'({raw_int[3], rx_level}), 0);
    rx_pop = 1'b1; clr_wr = 1'b1; clr_bits = 4'b0010;
    cyc();
    rx_pop = 1'b0; clr_wr = 1'b0; clr_bits = '0;
    chk("R6 set wins over clear", int'(raw_int[2]), 1);
    clear(4'b0010);
    chk("R6 clear rx underflow", int'(raw_int[2]), 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_thresholds();
    t_tx_path();
    t_tx_overflow();
    t_rx_path();
    t_rx_overflow();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule